// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Serialization

This block is a word-addressed on-chip scratchpad for a 32-lane execution group. The storage is split into one single-port bank per lane position. An access arrives through a valid/ready handshake. It carries one word address per lane, an active-lane mask, a read/write flag and one data word per lane. The block works out which lanes collide in a bank and runs the access as a series of passes. In each pass, every bank serves the lowest distinct address still pending in it. All lanes that named that address are served together, so lanes that read the same word share one broadcast.

When the last pass has finished, all lanes' read data is presented at once together with a one-cycle completion pulse. The number of passes the access needed is reported alongside it. This lets software-visible performance effects, such as padded versus unpadded tile layouts, be measured directly.

Top module: `bscratch`

## Requirements
- R1: The bank index of a word is its address modulo 32 (address bits [4:0]), and the row within the bank is the remaining upper address bits, so 32 consecutive addresses touch all 32 banks.
- R2: An access whose active lanes all fall in different banks completes in exactly one pass.
- R3: Two active lanes that hit one bank at different addresses force two passes.
- R4: Any number of active lanes reading the same address are served in one pass, and each of them receives that word.
- R5: The pass count reported on `out_passes` equals the largest number of distinct addresses requested within any single bank.
- R6: A column read over a 33-word-pitch tile (lane l reads l*33+c) takes one pass, and the same column read at a 32-word pitch takes 32 passes.
- R7: When several active lanes write one address in one access, the word stored is the data of the highest-numbered such lane.
- R8: `in_ready` is high only while idle. It drops after an accepted request and stays low until completion. `out_valid` is a single-cycle pulse that rises max(P,1) cycles after the accepting edge, where P is the pass count.
- R9: Inactive lanes neither write nor read. Their `out_rdata` field is zero, and an access with an empty mask completes with a pass count of 0.
- R10: A read returns the word most recently written to that address. For a write access, every lane's `out_rdata` field is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle and able to take a request |
| in_we | input | 1 | 1 = write access, 0 = read access |
| in_mask | input | LANES | Active lane mask, bit l for lane l |
| in_addr | input | LANES*AW | Word address of lane l in bits [l*AW +: AW] |
| in_wdata | input | LANES*DW | Write word of lane l in bits [l*DW +: DW] |
| out_valid | output | 1 | One-cycle completion pulse |
| out_rdata | output | LANES*DW | Read word of lane l in bits [l*DW +: DW], held until the next request |
| out_passes | output | PW | Number of passes used by the completed access |

## Verification
The assertions assume that the request fields stay meaningful only at the accepting edge. They also assume that no request is offered while the internal reset is still being released. The checker's latency counter relies on this, since it starts at the handshake. The stimulus raises `in_valid` only for the single cycle in which `in_ready` was seen high, and it waits several cycles after reset before the first request. The bench's model uses only addresses it has written beforehand, because the storage has no reset value.

// File: rtl/bscratch_pkg.sv
package bscratch_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } bs_state_t;
endpackage

// File: rtl/bscratch_rst_sync.sv
module bscratch_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end
endmodule

// File: rtl/bscratch_pick.sv
// Per-bank selector: finds the lowest pending address that maps to this
// bank, the set of lanes that asked for it, and the highest of those lanes.
module bscratch_pick #(
  parameter int LANES   = 32,
  parameter int AW      = 11,
  parameter int BANK_ID = 0
) (
  input  logic [LANES-1:0]         pend,
  input  logic [LANES-1:0][AW-1:0] addr,
  output logic                     hit,
  output logic [AW-1:0]            sel_addr,
  output logic [LANES-1:0]         serve,
  output logic [$clog2(LANES)-1:0] wr_lane
);
  localparam int BW = $clog2(LANES);
  localparam logic [BW-1:0] MY_BANK = BW'(BANK_ID);

  always_comb begin
    hit      = 1'b0;
    sel_addr = '0;
    for (int l = 0; l < LANES; l++) begin
      if (pend[l] && (addr[l][BW-1:0] == MY_BANK) &&
          (!hit || (addr[l] < sel_addr))) begin
        hit      = 1'b1;
        sel_addr = addr[l];
      end
    end
  end

  always_comb begin
    serve   = '0;
    wr_lane = '0;
    for (int l = 0; l < LANES; l++) begin
      if (hit && pend[l] && (addr[l] == sel_addr)) begin
        serve[l] = 1'b1;
        wr_lane  = ($clog2(LANES))'(l);
      end
    end
  end
endmodule

// File: rtl/bscratch_bank.sv
module bscratch_bank #(
  parameter int ROWS = 64,
  parameter int DW   = 32,
  localparam int RW  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [RW-1:0] row,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[row] <= wdata;
  end

  assign rdata = mem[row];
endmodule

// File: rtl/bscratch.sv
module bscratch #(
  parameter int LANES = 32,
  parameter int AW    = 11,
  parameter int DW    = 32,
  localparam int PW   = $clog2(LANES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic                  in_we,
  input  logic [LANES-1:0]      in_mask,
  input  logic [LANES*AW-1:0]   in_addr,
  input  logic [LANES*DW-1:0]   in_wdata,
  output logic                  out_valid,
  output logic [LANES*DW-1:0]   out_rdata,
  output logic [PW-1:0]         out_passes
);
  import bscratch_pkg::*;

  localparam int BANKS = LANES;
  localparam int BW    = $clog2(BANKS);
  localparam int ROWS  = (1 << AW) / BANKS;
  localparam int LW    = $clog2(LANES);

  logic srst_n;
  bscratch_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  // control registers
  bs_state_t          st_q, st_d;
  logic [LANES-1:0]   pend_q, pend_d;
  logic [PW-1:0]      pass_q, pass_d;
  // request / result holding registers (no reset, enabled loads)
  logic                     we_q;
  logic [LANES-1:0][AW-1:0] addr_q;
  logic [LANES-1:0][DW-1:0] wdata_q;
  logic [LANES-1:0][DW-1:0] rdata_q, rdata_d;
  logic                     req_en, rd_en;

  logic accept, running;
  assign in_ready = srst_n && (st_q == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign running  = (st_q == ST_RUN);

  // per-bank selection and storage
  logic [BANKS-1:0]                 bk_hit;
  logic [BANKS-1:0][AW-1:0]         bk_sel;
  logic [BANKS-1:0][LANES-1:0]      bk_serve;
  logic [BANKS-1:0][LW-1:0]         bk_wl;
  logic [BANKS-1:0][DW-1:0]         bk_rd;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    bscratch_pick #(.LANES(LANES), .AW(AW), .BANK_ID(b)) u_pick (
      .pend     (pend_q),
      .addr     (addr_q),
      .hit      (bk_hit[b]),
      .sel_addr (bk_sel[b]),
      .serve    (bk_serve[b]),
      .wr_lane  (bk_wl[b])
    );
    bscratch_bank #(.ROWS(ROWS), .DW(DW)) u_mem (
      .clk   (clk),
      .wr_en (running && we_q && bk_hit[b]),
      .row   (bk_sel[b][AW-1:BW]),
      .wdata (wdata_q[bk_wl[b]]),
      .rdata (bk_rd[b])
    );
  end

  logic [LANES-1:0] served;
  always_comb begin
    served = '0;
    for (int b = 0; b < BANKS; b++) served = served | bk_serve[b];
  end

  // next-state logic
  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    pass_d = pass_q;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        st_d   = ST_RUN;
        pend_d = in_mask;
        pass_d = '0;
      end
      ST_RUN: begin
        pend_d = pend_q & ~served;
        if (|served) pass_d = pass_q + 1'b1;
        if ((pend_q & ~served) == '0) st_d = ST_DONE;
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    req_en  = accept;
    rd_en   = accept || (running && !we_q);
    rdata_d = rdata_q;
    if (accept) begin
      rdata_d = '0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (served[l]) rdata_d[l] = bk_rd[addr_q[l][BW-1:0]];
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q   <= ST_IDLE;
      pend_q <= '0;
      pass_q <= '0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      pass_q <= pass_d;
    end
  end

  always_ff @(posedge clk) begin
    if (req_en) begin
      we_q    <= in_we;
      addr_q  <= in_addr;
      wdata_q <= in_wdata;
    end
    if (rd_en) rdata_q <= rdata_d;
  end

  assign out_valid  = (st_q == ST_DONE);
  assign out_rdata  = rdata_q;
  assign out_passes = pass_q;
endmodule

// File: rtl/bscratch_chk.sv
module bscratch_chk #(
  parameter int LANES = 32,
  parameter int PW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic [PW-1:0] out_passes
);
  logic [7:0] cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_q <= '0;
    else if (in_valid && in_ready) cyc_q <= '0;
    else if (!in_ready && !out_valid) cyc_q <= cyc_q + 1'b1;
  end

  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_done_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_pass_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_passes <= PW'(LANES)));

  p_latency_matches_passes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (cyc_q == ((out_passes == '0) ? 8'd1 : 8'(out_passes))));
endmodule

bind bscratch bscratch_chk #(.LANES(LANES), .PW(PW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_passes (out_passes)
);

// File: tb/bscratch_test.sv
`timescale 1ns/1ps
module bscratch_test;
  localparam int LANES = 32;
  localparam int AW    = 11;
  localparam int DW    = 32;
  localparam int PW    = $clog2(LANES + 1);
  localparam int WORDS = 1 << AW;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                in_valid, in_we, in_ready, out_valid;
  logic [LANES-1:0]    in_mask;
  logic [LANES*AW-1:0] in_addr;
  logic [LANES*DW-1:0] in_wdata, out_rdata;
  logic [PW-1:0]       out_passes;

  always #4 clk = ~clk;

  bscratch #(.LANES(LANES), .AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_we(in_we), .in_mask(in_mask), .in_addr(in_addr), .in_wdata(in_wdata),
    .out_valid(out_valid), .out_rdata(out_rdata), .out_passes(out_passes)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // reference state
  logic [31:0]      mm [WORDS];
  int               t_addr [LANES];
  logic [31:0]      t_wd [LANES];
  logic [LANES-1:0] t_mask;
  logic             t_we;
  logic [31:0]      seed = 32'h1357_9bdf;

  task automatic check(string req, logic [63:0] got, logic [63:0] expv);
    n_cmp++;
    if (got !== expv) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, expv, $time);
    end
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic logic [31:0] hash(int a);
    return (32'(a) * 32'h9E37_79B1) ^ 32'h0BAD_F00D;
  endfunction

  task automatic rnd(output logic [31:0] v);
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    v = seed;
  endtask

  // max number of distinct addresses in any bank among active lanes
  function automatic int model_passes();
    int worst = 0;
    for (int b = 0; b < LANES; b++) begin
      int cnt = 0;
      for (int l = 0; l < LANES; l++) begin
        if (t_mask[l] && (t_addr[l] % 32) == b) begin
          bit seen = 0;
          for (int j = 0; j < l; j++)
            if (t_mask[j] && t_addr[j] == t_addr[l]) seen = 1;
          if (!seen) cnt++;
        end
      end
      if (cnt > worst) worst = cnt;
    end
    return worst;
  endfunction

  // runs one access starting at a negedge; want < 0 uses the model count
  task automatic run_acc(string req, int want);
    logic [31:0] erd [LANES];
    int p, r, ep;
    p  = model_passes();
    ep = (want >= 0) ? want : p;
    r  = (p == 0) ? 1 : p;
    for (int l = 0; l < LANES; l++)
      erd[l] = (t_mask[l] && !t_we) ? mm[t_addr[l]] : 32'h0;
    if (t_we)
      for (int l = 0; l < LANES; l++)
        if (t_mask[l]) mm[t_addr[l]] = t_wd[l];   // highest lane last (R7)
    check("R8 idle ready", {63'b0, in_ready}, 64'd1);
    check("R8 idle no valid", {63'b0, out_valid}, 64'd0);
    in_valid = 1'b1;
    in_we    = t_we;
    in_mask  = t_mask;
    for (int l = 0; l < LANES; l++) begin
      in_addr[l*AW +: AW]  = AW'(t_addr[l]);
      in_wdata[l*DW +: DW] = t_wd[l];
    end
    @(negedge clk);
    in_valid = 1'b0;
    for (int n = 1; n <= r; n++) begin
      check("R8 busy ready low", {63'b0, in_ready}, 64'd0);
      check("R8 busy no valid", {63'b0, out_valid}, 64'd0);
      @(negedge clk);
    end
    check({"R8 completion ", req}, {63'b0, out_valid}, 64'd1);
    check({"R5 passes ", req}, 64'(out_passes), 64'(ep));
    for (int l = 0; l < LANES; l++)
      check(t_mask[l] ? {"R10 data ", req} : {"R9 inactive lane ", req},
            64'(out_rdata[l*DW +: DW]), 64'(erd[l]));
    @(negedge clk);
    check("R8 pulse ends", {63'b0, out_valid}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    finish_up();
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; in_valid = 1'b0; in_we = 1'b0;
    in_mask = '0; in_addr = '0; in_wdata = '0;
    repeat (3) @(negedge clk);
    check("R8 reset valid low", {63'b0, out_valid}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 ready after reset", {63'b0, in_ready}, 64'd1);

    // R1 R2: fill the whole store, consecutive addresses, one pass each
    for (int blk = 0; blk < WORDS / LANES; blk++) begin
      t_we = 1; t_mask = '1;
      for (int l = 0; l < LANES; l++) begin
        t_addr[l] = blk * LANES + l; t_wd[l] = hash(t_addr[l]);
      end
      run_acc("R1 R2 fill", 1);
    end

    // R1 R10: consecutive read with an offset wraps through all banks
    t_we = 0; t_mask = '1;
    for (int l = 0; l < LANES; l++) t_addr[l] = 5 + l;
    run_acc("R1 offset read", 1);

    // R4: broadcast read
    for (int l = 0; l < LANES; l++) t_addr[l] = 77;
    run_acc("R4 broadcast", 1);

    // R3: two lanes, same bank, different rows
    t_mask = 32'h3; t_addr[0] = 3; t_addr[1] = 35;
    run_acc("R3 two-way conflict", 2);

    // R6: padded tile columns and unpadded column
    t_mask = '1;
    for (int l = 0; l < LANES; l++) t_addr[l] = l * 33;
    run_acc("R6 padded col0", 1);
    for (int l = 0; l < LANES; l++) t_addr[l] = l * 33 + 5;
    run_acc("R6 padded col5", 1);
    for (int l = 0; l < LANES; l++) t_addr[l] = l * 32 + 2;
    run_acc("R6 unpadded", 32);

    // R5: four distinct rows in bank 4 with a shared reader
    t_mask = 32'h1F;
    t_addr[0] = 4; t_addr[1] = 36; t_addr[2] = 68; t_addr[3] = 36; t_addr[4] = 100;
    run_acc("R5 mixed", 4);

    // R7: all lanes write one word; then without lane 31
    t_we = 1; t_mask = '1;
    for (int l = 0; l < LANES; l++) begin t_addr[l] = 100; t_wd[l] = 32'(l + 1); end
    run_acc("R7 all writers", 1);
    t_we = 0; t_mask = 32'h1; t_addr[0] = 100;
    run_acc("R7 readback", 1);
    t_we = 1; t_mask = 32'h7FFF_FFFF;
    for (int l = 0; l < LANES; l++) begin t_addr[l] = 200; t_wd[l] = 32'(l + 32'h50); end
    run_acc("R7 partial writers", 1);
    t_we = 0; t_mask = 32'h1; t_addr[0] = 200;
    run_acc("R7 partial readback", 1);

    // R9: masked-off lane is not written
    t_we = 1; t_mask = ~32'h80;
    for (int l = 0; l < LANES; l++) begin t_addr[l] = 300 + l; t_wd[l] = ~hash(l); end
    run_acc("R9 masked write", 1);
    t_we = 0; t_mask = '1;
    run_acc("R9 masked readback", 1);
    t_mask = 32'h0F0F;
    run_acc("R9 partial read", 1);
    t_mask = '0;
    run_acc("R9 empty mask", 0);

    // R5 R10: pseudo-random accesses
    for (int k = 0; k < 60; k++) begin
      rnd(v); t_we = v[0];
      rnd(v); t_mask = v;
      for (int l = 0; l < LANES; l++) begin
        rnd(v);
        t_addr[l] = (k % 3 == 0) ? int'(v[4:0]) * 32 + int'(v[9:8]) : int'(v[AW-1:0]);
        rnd(t_wd[l]);
      end
      run_acc("R5 random", -1);
    end

    finish_up();
  end
endmodule